// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Update Engine

This block updates the membrane potentials of spiking neurons in several parallel lanes. Each lane takes a potential increment tagged with a lane-local neuron index. The increment is the already-summed effect of binary input spikes, so the lane adds it to the potential without any multiply. The lane reads the stored potential from its own bank of an external potential memory. It then forms potential plus increment minus the layer leak in one three-operand add and compares the result with the layer threshold. On a crossing it clears the potential and raises a spike that carries the neuron index. The final value is written back in every case.

All lanes share one ready/valid handshake on the increment stream and one leak/threshold pair, which is loaded through a configuration strobe. A spike output that is not taken stalls the whole engine. A read-after-write bypass keeps back-to-back updates of one neuron correct without any idle cycles.

Top module: `lif_update_engine`

## Requirements
- R1: An increment accepted on lane l (in_valid[l] and in_ready high at a clock edge) issues a memory read of its index in that same cycle. Read data is expected one cycle later. In the next cycle that is not stalled, the lane writes sat(old + increment − leak) to the same index of bank l. All values are signed two's complement of POT_W bits.
- R2: The leak is subtracted on every update, including updates whose increment is zero.
- R3: When old + increment − leak is greater than or equal to the threshold (signed compare), the value written back is zero.
- R4: The cycle after a write that crossed the threshold, spk_valid[l] is high and spk_idx carries that neuron index. spk_valid[l] is low in every other cycle, except while an earlier spike is being held.
- R5: A result below the most negative POT_W-bit value is written as that value (−32768 for 16 bits) instead of wrapping.
- R6: Updates of the same neuron on consecutive accepted cycles of a lane each use the value produced by the previous update, even though the memory returns the old contents on a read that coincides with a write.
- R7: A cfg_wr pulse loads cfg_leak and cfg_thresh. The new pair applies to every increment accepted in the same cycle as the pulse or later. After reset the leak is 0 and the threshold is the largest positive value.
- R8: While any spk_valid is high and spk_ready is low, in_ready is low, no memory read or write is issued, and the spike outputs hold. No update is lost or repeated across the stall.
- R9: During and right after reset, in_ready is high and spk_valid and mem_wr_en are all low.
- R10: Lanes work independently and in parallel. A lane whose in_valid is low issues no read and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Per-lane increment valid |
| in_ready | output | 1 | Shared acceptance for all lanes |
| in_idx | input | LANES*IDX_W | Per-lane neuron index |
| in_inc | input | LANES*POT_W | Per-lane signed potential increment |
| cfg_wr | input | 1 | Load strobe for leak and threshold |
| cfg_leak | input | POT_W | Signed layer leak |
| cfg_thresh | input | POT_W | Signed layer threshold |
| mem_rd_en | output | LANES | Per-bank read enable |
| mem_rd_addr | output | LANES*IDX_W | Per-bank read address |
| mem_rd_data | input | LANES*POT_W | Per-bank read data, one cycle after the read |
| mem_wr_en | output | LANES | Per-bank write enable |
| mem_wr_addr | output | LANES*IDX_W | Per-bank write address |
| mem_wr_data | output | LANES*POT_W | Per-bank write data |
| spk_valid | output | LANES | Per-lane spike strobe |
| spk_idx | output | LANES*IDX_W | Index of the neuron that fired |
| spk_ready | input | 1 | Spike consumer can take the spikes |

## Verification
Two functions can fall in the same lane cycle: the write-back of a neuron and a fresh read of that same neuron. The bench provokes this with runs of one index sent on consecutive cycles and with alternating index pairs. A reference model that updates potentials strictly in arrival order then judges every written value. The second collision is a spike stall landing on a lane whose operand has just arrived from memory. Random spk_ready, with indices drawn from a small set, makes stalls overlap bypassed updates, and every write and spike is compared cycle by cycle against the model.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int LIF_LANES = 8;
  localparam int LIF_POT_W = 16;
  localparam int LIF_IDX_W = 6;

  // where a lane takes the old potential from
  typedef enum logic [1:0] {
    OPD_MEM  = 2'd0,
    OPD_FWD  = 2'd1,
    OPD_HOLD = 2'd2
  } lif_opd_e;
endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs #(
  parameter int POT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic signed [POT_W-1:0] leak_in,
  input  logic signed [POT_W-1:0] thr_in,
  output logic signed [POT_W-1:0] leak_q,
  output logic signed [POT_W-1:0] thr_q
);
  localparam logic signed [POT_W-1:0] THR_RST = {1'b0, {(POT_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leak_q <= '0;
      thr_q  <= THR_RST;
    end else if (wr) begin
      leak_q <= leak_in;
      thr_q  <= thr_in;
    end
  end
endmodule

// File: rtl/lif_stall_ctrl.sv
module lif_stall_ctrl #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] spk_vld,
  input  logic             spk_ready,
  output logic             adv
);
  logic spike_blocked;
  assign spike_blocked = (|spk_vld) && !spk_ready;
  assign adv = !spike_blocked;
endmodule

// File: rtl/lif_lane.sv
module lif_lane
  import lif_pkg::*;
#(
  parameter int POT_W = 16,
  parameter int IDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    in_vld,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic signed [POT_W-1:0] in_inc,
  output logic                    rd_en,
  output logic [IDX_W-1:0]        rd_addr,
  input  logic signed [POT_W-1:0] rd_data,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_addr,
  output logic signed [POT_W-1:0] wr_data,
  input  logic signed [POT_W-1:0] leak,
  input  logic signed [POT_W-1:0] thr,
  output logic                    spk_vld,
  output logic [IDX_W-1:0]        spk_idx,
  output logic                    fire,
  output logic                    sat_hit
);
  localparam int SUM_W = POT_W + 2;
  localparam logic signed [POT_W-1:0] POT_MIN = {1'b1, {(POT_W-1){1'b0}}};

  function automatic logic signed [SUM_W-1:0] sx(input logic signed [POT_W-1:0] v);
    return $signed({{(SUM_W-POT_W){v[POT_W-1]}}, v});
  endfunction

  // three-operand add: old + increment - leak
  function automatic logic signed [SUM_W-1:0] step_sum(
    input logic signed [POT_W-1:0] p,
    input logic signed [POT_W-1:0] i,
    input logic signed [POT_W-1:0] l);
    return sx(p) + sx(i) - sx(l);
  endfunction

  function automatic logic reaches(input logic signed [SUM_W-1:0] s,
                                   input logic signed [POT_W-1:0] t);
    return s >= sx(t);
  endfunction

  function automatic logic below_min(input logic signed [SUM_W-1:0] s);
    return s < sx(POT_MIN);
  endfunction

  // stage A: operand arrives from memory, result computed and written
  logic                    a_vld, a_first;
  logic [IDX_W-1:0]        a_idx;
  logic signed [POT_W-1:0] a_inc, a_hold;
  // record of the most recent write of this lane
  logic                    fwd_vld;
  logic [IDX_W-1:0]        fwd_idx;
  logic signed [POT_W-1:0] fwd_pot;

  lif_opd_e                opd_sel;
  logic signed [POT_W-1:0] opd, nxt_pot;
  logic signed [SUM_W-1:0] sum;
  logic                    fwd_hit;

  assign rd_en   = in_vld && adv;
  assign rd_addr = in_idx;

  assign fwd_hit = a_first && fwd_vld && (fwd_idx == a_idx);

  always_comb begin
    if (!a_first)     opd_sel = OPD_HOLD;
    else if (fwd_hit) opd_sel = OPD_FWD;
    else              opd_sel = OPD_MEM;
    case (opd_sel)
      OPD_FWD:  opd = fwd_pot;
      OPD_HOLD: opd = a_hold;
      default:  opd = rd_data;
    endcase
  end

  assign sum     = step_sum(opd, a_inc, leak);
  assign fire    = a_vld && reaches(sum, thr);
  assign sat_hit = a_vld && !fire && below_min(sum);

  always_comb begin
    if (fire)         nxt_pot = '0;
    else if (sat_hit) nxt_pot = POT_MIN;
    else              nxt_pot = sum[POT_W-1:0];
  end

  assign wr_en   = a_vld && adv;
  assign wr_addr = a_idx;
  assign wr_data = nxt_pot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld   <= 1'b0;
      a_first <= 1'b0;
      a_idx   <= '0;
      a_inc   <= '0;
      a_hold  <= '0;
      fwd_vld <= 1'b0;
      fwd_idx <= '0;
      fwd_pot <= '0;
      spk_vld <= 1'b0;
      spk_idx <= '0;
    end else begin
      if (a_vld) a_hold <= opd;
      if (adv) begin
        a_vld   <= in_vld;
        a_first <= in_vld;
        if (in_vld) begin
          a_idx <= in_idx;
          a_inc <= in_inc;
        end
        if (a_vld) begin
          fwd_vld <= 1'b1;
          fwd_idx <= a_idx;
          fwd_pot <= nxt_pot;
        end
        spk_vld <= fire;
        spk_idx <= a_idx;
      end else begin
        a_first <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lif_update_engine.sv
module lif_update_engine
  import lif_pkg::*;
#(
  parameter int LANES = LIF_LANES,
  parameter int POT_W = LIF_POT_W,
  parameter int IDX_W = LIF_IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_valid,
  output logic                   in_ready,
  input  logic [LANES*IDX_W-1:0] in_idx,
  input  logic [LANES*POT_W-1:0] in_inc,
  input  logic                   cfg_wr,
  input  logic [POT_W-1:0]       cfg_leak,
  input  logic [POT_W-1:0]       cfg_thresh,
  output logic [LANES-1:0]       mem_rd_en,
  output logic [LANES*IDX_W-1:0] mem_rd_addr,
  input  logic [LANES*POT_W-1:0] mem_rd_data,
  output logic [LANES-1:0]       mem_wr_en,
  output logic [LANES*IDX_W-1:0] mem_wr_addr,
  output logic [LANES*POT_W-1:0] mem_wr_data,
  output logic [LANES-1:0]       spk_valid,
  output logic [LANES*IDX_W-1:0] spk_idx,
  input  logic                   spk_ready
);
  logic                    adv;
  logic signed [POT_W-1:0] leak_q, thr_q;
  logic [LANES-1:0]        lane_fire, lane_sat;

  lif_cfg_regs #(.POT_W(POT_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .leak_in(cfg_leak),
    .thr_in (cfg_thresh),
    .leak_q (leak_q),
    .thr_q  (thr_q)
  );

  lif_stall_ctrl #(.LANES(LANES)) u_stall (
    .spk_vld  (spk_valid),
    .spk_ready(spk_ready),
    .adv      (adv)
  );

  assign in_ready = adv;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lif_lane #(.POT_W(POT_W), .IDX_W(IDX_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .in_vld (in_valid[g]),
      .in_idx (in_idx[g*IDX_W +: IDX_W]),
      .in_inc (in_inc[g*POT_W +: POT_W]),
      .rd_en  (mem_rd_en[g]),
      .rd_addr(mem_rd_addr[g*IDX_W +: IDX_W]),
      .rd_data(mem_rd_data[g*POT_W +: POT_W]),
      .wr_en  (mem_wr_en[g]),
      .wr_addr(mem_wr_addr[g*IDX_W +: IDX_W]),
      .wr_data(mem_wr_data[g*POT_W +: POT_W]),
      .leak   (leak_q),
      .thr    (thr_q),
      .spk_vld(spk_valid[g]),
      .spk_idx(spk_idx[g*IDX_W +: IDX_W]),
      .fire   (lane_fire[g]),
      .sat_hit(lane_sat[g])
    );
  end
endmodule

// File: rtl/lif_update_engine_chk.sv
module lif_update_engine_chk #(
  parameter int LANES = 8,
  parameter int POT_W = 16,
  parameter int IDX_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   spk_ready,
  input logic [LANES-1:0]       spk_valid,
  input logic [LANES*IDX_W-1:0] spk_idx,
  input logic [LANES-1:0]       mem_rd_en,
  input logic [LANES-1:0]       mem_wr_en,
  input logic [LANES*IDX_W-1:0] mem_wr_addr,
  input logic [LANES*POT_W-1:0] mem_wr_data,
  input logic [LANES-1:0]       lane_fire,
  input logic [LANES-1:0]       lane_sat
);
  localparam logic [POT_W-1:0] MIN_V = {1'b1, {(POT_W-1){1'b0}}};

  // R8
  stall_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|spk_valid) && !spk_ready) |-> (mem_wr_en == '0 && mem_rd_en == '0 && !in_ready));

  // R8
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> ((|spk_valid) && !spk_ready));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R8
    spike_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spk_valid[l] && !spk_ready) |=>
        (spk_valid[l] && $stable(spk_idx[l*IDX_W +: IDX_W])));

    // R3
    spike_zero_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spk_valid[l] && $past(mem_wr_en[l])) |->
        ($past(mem_wr_data[l*POT_W +: POT_W]) == '0 &&
         $past(mem_wr_addr[l*IDX_W +: IDX_W]) == spk_idx[l*IDX_W +: IDX_W]));

    // R4
    fire_to_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_fire[l] && in_ready) |=> spk_valid[l]);

    // R5
    floor_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_sat[l] && in_ready) |->
        (mem_wr_en[l] && mem_wr_data[l*POT_W +: POT_W] == MIN_V));
  end
endmodule

bind lif_update_engine lif_update_engine_chk #(
  .LANES(LANES), .POT_W(POT_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .spk_ready  (spk_ready),
  .spk_valid  (spk_valid),
  .spk_idx    (spk_idx),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data),
  .lane_fire  (lane_fire),
  .lane_sat   (lane_sat)
);

// File: tb/lif_update_engine_test.sv
module lif_update_engine_test;
  localparam int L = 8;
  localparam int P = 16;
  localparam int I = 6;
  localparam int D = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [L-1:0]   in_valid = '0;
  logic           in_ready;
  logic [L*I-1:0] in_idx = '0;
  logic [L*P-1:0] in_inc = '0;
  logic           cfg_wr = 1'b0;
  logic [P-1:0]   cfg_leak = '0;
  logic [P-1:0]   cfg_thresh = '0;
  logic [L-1:0]   mem_rd_en;
  logic [L*I-1:0] mem_rd_addr;
  logic [L*P-1:0] mem_rd_data;
  logic [L-1:0]   mem_wr_en;
  logic [L*I-1:0] mem_wr_addr;
  logic [L*P-1:0] mem_wr_data;
  logic [L-1:0]   spk_valid;
  logic [L*I-1:0] spk_idx;
  logic           spk_ready;

  always #10 clk = ~clk;

  lif_update_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_inc(in_inc), .cfg_wr(cfg_wr), .cfg_leak(cfg_leak),
    .cfg_thresh(cfg_thresh), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .spk_valid(spk_valid), .spk_idx(spk_idx),
    .spk_ready(spk_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit bp_on = 1'b0;
  string cur_req = "R1";

  function automatic int init_val(int l, int i);
    return ((l * 53 + i * 29) % 241) - 120;
  endfunction

  // potential memory: one-cycle read, old data on a colliding read
  logic signed [P-1:0] mem [L][D];
  always @(posedge clk) begin
    for (int l = 0; l < L; l++) begin
      if (!rst_n) begin
        for (int i = 0; i < D; i++) mem[l][i] <= P'(init_val(l, i));
        mem_rd_data[l*P +: P] <= '0;
      end else begin
        if (mem_rd_en[l]) mem_rd_data[l*P +: P] <= mem[l][mem_rd_addr[l*I +: I]];
        if (mem_wr_en[l]) mem[l][mem_wr_addr[l*I +: I]] <= mem_wr_data[l*P +: P];
      end
    end
  end

  always @(negedge clk) spk_ready = bp_on ? 1'($urandom % 2) : 1'b1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int ref_pot [L][D];
  int ref_leak, ref_thr;
  bit pend_w [L];
  int pend_addr [L];
  int pend_data [L];
  bit pend_spk [L];
  bit spk_pend [L];
  int spk_exp [L];

  always @(negedge clk) begin
    bit stall_obs;
    int s, np, ix;
    #2;
    if (!rst_n) begin
      ref_leak = 0;
      ref_thr  = 32767;
      for (int l = 0; l < L; l++) begin
        for (int i = 0; i < D; i++) ref_pot[l][i] = init_val(l, i);
        pend_w[l] = 0; pend_spk[l] = 0; spk_pend[l] = 0;
      end
    end else begin
      stall_obs = (|spk_valid) && !spk_ready;
      chk("R8", "in_ready", in_ready, !stall_obs);
      for (int l = 0; l < L; l++) begin
        chk("R4", "spike strobe", spk_valid[l], spk_pend[l]);
        if (spk_pend[l] && spk_valid[l])
          chk("R4", "spike index", spk_idx[l*I +: I], spk_exp[l]);
        if (spk_valid[l] && spk_ready) spk_pend[l] = 0;
        chk("R1", "write timing", mem_wr_en[l], pend_w[l] && !stall_obs);
        if (pend_w[l] && !stall_obs && mem_wr_en[l]) begin
          chk(cur_req, "write addr", mem_wr_addr[l*I +: I], pend_addr[l]);
          chk(cur_req, "write data", $signed(mem_wr_data[l*P +: P]), pend_data[l]);
          if (pend_spk[l]) begin
            spk_pend[l] = 1;
            spk_exp[l] = pend_addr[l];
          end
          pend_w[l] = 0;
        end
        chk("R10", "read enable", mem_rd_en[l], in_valid[l] && in_ready);
        if (mem_rd_en[l]) chk("R1", "read addr", mem_rd_addr[l*I +: I], in_idx[l*I +: I]);
      end
      if (cfg_wr) begin
        ref_leak = $signed(cfg_leak);
        ref_thr  = $signed(cfg_thresh);
      end
      if (in_ready) begin
        for (int l = 0; l < L; l++) begin
          if (in_valid[l]) begin
            ix = in_idx[l*I +: I];
            s = ref_pot[l][ix] + $signed(in_inc[l*P +: P]) - ref_leak;
            pend_spk[l] = (s >= ref_thr);
            if (pend_spk[l]) np = 0;
            else if (s < -32768) np = -32768;
            else np = s;
            ref_pot[l][ix] = np;
            pend_w[l] = 1; pend_addr[l] = ix; pend_data[l] = np;
          end
        end
      end
    end
  end

  task automatic send(input logic [L-1:0] m, input logic [L*I-1:0] ix,
                      input logic [L*P-1:0] ic, input bit dc, input int lk, input int th);
    @(negedge clk);
    in_valid = m; in_idx = ix; in_inc = ic;
    cfg_wr = dc; cfg_leak = P'(lk); cfg_thresh = P'(th);
    #2;
    while (!in_ready) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      #2;
    end
    @(posedge clk);
  endtask

  task automatic send1(input int lane, input int idx, input int inc);
    logic [L*I-1:0] ix;
    logic [L*P-1:0] ic;
    ix = '0; ic = '0;
    ix[lane*I +: I] = I'(idx);
    ic[lane*P +: P] = P'(inc);
    send(L'(1) << lane, ix, ic, 1'b0, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = '0;
      cfg_wr = 1'b0;
    end
  endtask

  task automatic cfg(input int lk, input int th);
    @(negedge clk);
    in_valid = '0;
    cfg_wr = 1'b1; cfg_leak = P'(lk); cfg_thresh = P'(th);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rand_burst(input int n, input int idx_mask, input int span);
    logic [L-1:0]   m;
    logic [L*I-1:0] ix;
    logic [L*P-1:0] ic;
    for (int k = 0; k < n; k++) begin
      m = L'($urandom);
      for (int l = 0; l < L; l++) begin
        ix[l*I +: I] = I'($urandom & idx_mask);
        ic[l*P +: P] = P'(int'($urandom % (2 * span + 1)) - span);
      end
      send(m, ix, ic, 1'b0, 0, 0);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int inc;
    repeat (3) @(negedge clk);
    #3;
    // R9: reset values
    chk("R9", "in_ready in reset", in_ready, 1);
    chk("R9", "spk_valid in reset", spk_valid, 0);
    chk("R9", "mem_wr_en in reset", mem_wr_en, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #3;
    chk("R9", "spk_valid after reset", spk_valid, 0);
    chk("R9", "mem_wr_en after reset", mem_wr_en, 0);

    // R1: plain accumulation with reset leak and threshold
    cur_req = "R1";
    send1(0, 3, 100); send1(0, 4, -50); send1(0, 3, 7);
    idle(3);

    // R2: leak with zero increments
    cur_req = "R2";
    cfg(7, 32767);
    for (int k = 0; k < 10; k++) send1(0, 12, 0);
    idle(3);

    // R3: exact threshold crossing and one short of it
    cur_req = "R3";
    cfg(3, 50);
    send1(1, 7, 50 + 3 - ref_pot[1][7]);
    idle(2);
    send1(1, 7, 49 + 3 - ref_pot[1][7]);
    idle(2);
    inc = 50 + 3 - ref_pot[1][7];
    send1(1, 7, inc);
    idle(3);

    // R5: floor at the most negative value
    cur_req = "R5";
    cfg(20000, 32767);
    send1(2, 5, -20000); send1(2, 5, -20000); send1(2, 6, -30000);
    idle(3);

    // R6: same neuron on consecutive cycles, then an alternating pair
    cur_req = "R6";
    cfg(1, 30000);
    for (int k = 0; k < 5; k++) send1(3, 9, 10);
    for (int k = 0; k < 6; k++) send1(3, (k % 2) ? 4 : 9, 25);
    cfg(2, 20);
    for (int k = 0; k < 6; k++) send1(3, 9, 15);
    idle(3);

    // R7: new pair applies to the increment accepted in the same cycle
    cur_req = "R7";
    send1(4, 2, 10);
    send(L'(1) << 4, {L{I'(2)}}, {L{P'(10)}}, 1'b1, 10, -1000);
    idle(3);

    // R10: all lanes in parallel with random masks
    cur_req = "R10";
    cfg(2, 150);
    rand_burst(200, 63, 200);
    idle(3);

    // R8: random spike back-pressure with heavy index reuse
    cur_req = "R8";
    cfg(1, 60);
    bp_on = 1'b1;
    rand_burst(300, 3, 40);
    idle(2);
    bp_on = 1'b0;
    idle(20);
    for (int l = 0; l < L; l++) begin
      chk("R8", "drained write", pend_w[l], 0);
      chk("R8", "drained spike", spk_pend[l], 0);
    end

    done = 1'b1;
    report();
  end
endmodule